// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Controller

This block turns a bank of general-purpose input pins into one interrupt request. Every pin carries four interrupt sources: pin low, pin high, falling edge and rising edge. Software can enable each source separately. The per-pin 4-bit fields are packed eight to a 32-bit word. The block shows three register views built from those fields: an enable view that software writes, a raw status view that shows every event whether or not it is enabled, and a masked status view that keeps only the enabled events.

Pin inputs first pass through a synchroniser. Edge events are held in raw status until software writes a one to the bit to clear it. The level sources always follow the synchronised pin. The interrupt line is the registered OR of all masked status bits.

Software uses a plain word-wide port. The address selects one view and one word, a write takes effect on the clock edge, and read data depends combinationally on the address. The port has no bus protocol and no byte enables: every write replaces or clears a full word.

Top module: `pin_event_irq`

## Requirements
- R1: Pin n owns bits [4*(n mod 8)+3 : 4*(n mod 8)] of word n/8 in every view. Within a field, bit 0 is the low-level source, bit 1 the high-level source, bit 2 the falling-edge source and bit 3 the rising-edge source.
- R2: In the raw view, the level bits follow the synchronised pin. A pin value sampled at clock edge k shows in the level bits after edge k+1. Bit 1 equals the pin value and bit 0 equals its inverse.
- R3: When the synchronised pin changes from one cycle to the next, the matching edge bit (rise 0 to 1, fall 1 to 0) is set in the raw view on the following clock edge. It stays set until it is cleared.
- R4: A write to the raw view clears each edge bit whose data bit is one. Data bits that are zero leave their edge bits unchanged, and the level bits are never affected by such a write.
- R5: If an edge is detected in the same cycle as a clear write to its bit, the bit stays set.
- R6: A write to the enable view replaces the whole addressed word on the next edge. Field positions past the last pin (pin 31 with the default 31 pins) always read zero.
- R7: The masked view reads as the bitwise AND of the raw and enable views. Writes to the masked view change nothing.
- R8: The interrupt output is high exactly one cycle after any masked status bit is high.
- R9: After reset, all enables and edge latches are zero, the synchronised pins are zero, and the interrupt output is low.
- R10: Address bits [3:2] select the view (0 enable, 1 masked, 2 raw, 3 reads zero and ignores writes). Address bits [1:0] select the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 31 | Asynchronous pin levels |
| regAddr | input | 4 | View select and word select |
| regWrEn | input | 1 | Write strobe for the addressed word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the addressed word (combinational) |
| irqOut | output | 1 | Combined registered interrupt request |

## Verification
The bench aims at a clear write that lands in the same cycle as a new edge. A design that lets the clear win loses the event and reads zero where a one is expected. It times the synchroniser and edge latency cycle by cycle, so a missing or extra flop shows up as a level or edge bit that changes one cycle early or late. Random writes to every view check three things: clears must leave zero data bits and level bits alone, writes to the masked view and the spare view must not change the enables, and the unused field of pin 31 must stay zero. A design that decodes the view wrongly or lets a clear reach the wrong bit then disagrees with the bench's reference model.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  // Width of one per-pin field and the position of each source inside it
  localparam int FIELD_W  = 4;
  localparam int BIT_LOW  = 0;
  localparam int BIT_HIGH = 1;
  localparam int BIT_FALL = 2;
  localparam int BIT_RISE = 3;

  // View selected by the upper address bits
  typedef enum logic [1:0] {
    VIEW_ENABLE = 2'd0,
    VIEW_MASKED = 2'd1,
    VIEW_RAW    = 2'd2,
    VIEW_NONE   = 2'd3
  } view_e;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic enWrite;
    logic rawClear;
  } reg_strobe_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= dIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int WORD_W = 2,
  localparam int ADDR_W = WORD_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output reg_strobe_t       strobe,
  output logic [WORD_W-1:0] wordSel,
  output view_e             viewSel
);

  // R10: upper two address bits pick the view, lower bits pick the word
  assign viewSel = view_e'(regAddr[ADDR_W-1:WORD_W]);
  assign wordSel = regAddr[WORD_W-1:0];

  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      unique case (viewSel)
        VIEW_ENABLE: strobe.enWrite  = 1'b1;
        VIEW_RAW:    strobe.rawClear = 1'b1;
        default:     strobe          = '0;  // masked and spare views: no effect
      endcase
    end
  end

  // R10: at most one write strobe per cycle
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.enWrite, strobe.rawClear}));

  // R7: a write aimed at the masked view raises no strobe
  assert_masked_write_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr[ADDR_W-1:WORD_W] == 2'd1) |-> (strobe == '0));

endmodule

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 31,
  parameter int DATA_W      = 32,
  parameter int NUM_WORDS   = 4,
  parameter int WORD_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  reg_strobe_t       strobe,
  input  logic [WORD_W-1:0] wordSel,
  input  view_e             viewSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  localparam int PINS_PER_WORD = DATA_W / FIELD_W;
  localparam int FLAT_W        = NUM_WORDS * DATA_W;
  localparam int USED_W        = NUM_PINS * FIELD_W;

  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] pinPrev;
  logic [NUM_PINS-1:0] riseNew;
  logic [NUM_PINS-1:0] fallNew;
  logic [NUM_PINS-1:0] riseLat;
  logic [NUM_PINS-1:0] fallLat;
  logic [NUM_PINS-1:0] riseClr;
  logic [NUM_PINS-1:0] fallClr;
  logic [NUM_PINS-1:0] enHit;

  logic [FLAT_W-1:0] rawFlat;
  logic [FLAT_W-1:0] enFlat;
  logic [FLAT_W-1:0] maskFlat;

  // Previous synchronised value for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;
  end

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int WORD_IDX = p / PINS_PER_WORD;
      localparam int BASE     = (p % PINS_PER_WORD) * FIELD_W;
      localparam int FBASE    = p * FIELD_W;

      logic             wordHit;
      logic [FIELD_W-1:0] enField;

      pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rstN (rstN),
        .dIn  (pinIn[p]),
        .dOut (pinSync[p])
      );

      assign wordHit    = (wordSel == WORD_W'(WORD_IDX));
      assign riseNew[p] = pinSync[p] & ~pinPrev[p];
      assign fallNew[p] = ~pinSync[p] & pinPrev[p];
      assign riseClr[p] = strobe.rawClear & wordHit & wrData[BASE+BIT_RISE];
      assign fallClr[p] = strobe.rawClear & wordHit & wrData[BASE+BIT_FALL];
      assign enHit[p]   = strobe.enWrite & wordHit;

      // Edge latches: new edge wins over a clear in the same cycle (R5)
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          riseLat[p] <= 1'b0;
          fallLat[p] <= 1'b0;
        end else begin
          riseLat[p] <= (riseLat[p] & ~riseClr[p]) | riseNew[p];
          fallLat[p] <= (fallLat[p] & ~fallClr[p]) | fallNew[p];
        end
      end

      // Enable field for this pin (R6)
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       enField <= '0;
        else if (enHit[p]) enField <= wrData[BASE +: FIELD_W];
      end

      // R1: field layout inside the flat views
      assign rawFlat[FBASE+BIT_LOW]  = ~pinSync[p];
      assign rawFlat[FBASE+BIT_HIGH] = pinSync[p];
      assign rawFlat[FBASE+BIT_FALL] = fallLat[p];
      assign rawFlat[FBASE+BIT_RISE] = riseLat[p];
      assign enFlat[FBASE +: FIELD_W] = enField;
    end

    if (FLAT_W > USED_W) begin : g_pad
      assign rawFlat[FLAT_W-1:USED_W] = '0;
      assign enFlat[FLAT_W-1:USED_W]  = '0;
    end
  endgenerate

  assign maskFlat = rawFlat & enFlat;

  // Combined interrupt, registered (R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |maskFlat;
  end

  // Read mux (R10)
  always_comb begin
    rdData = '0;
    if (int'(wordSel) < NUM_WORDS) begin
      unique case (viewSel)
        VIEW_ENABLE: rdData = enFlat[int'(wordSel)*DATA_W +: DATA_W];
        VIEW_MASKED: rdData = maskFlat[int'(wordSel)*DATA_W +: DATA_W];
        VIEW_RAW:    rdData = rawFlat[int'(wordSel)*DATA_W +: DATA_W];
        default:     rdData = '0;
      endcase
    end
  end

  // R4: a latched edge only drops when a clear for it was written
  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(riseLat) & ~$past(riseClr)) & ~riseLat) == '0) &&
    ((($past(fallLat) & ~$past(fallClr)) & ~fallLat) == '0));

  // R5: every detected edge is latched on the next edge, clear or not
  assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (($past(riseNew) & ~riseLat) == '0) && (($past(fallNew) & ~fallLat) == '0));

  // R6: enables change only on an enable write
  assert_enable_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enWrite |=> $stable(enFlat));

  // R8: interrupt follows masked status one cycle later
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|maskFlat) |=> irqOut);

  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(|maskFlat) |=> !irqOut);

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 31,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int PINS_PER_WORD = DATA_W / FIELD_W,
  localparam int NUM_WORDS  = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD,
  localparam int WORD_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W     = WORD_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic                irqOut
);

  reg_strobe_t       strobe;
  logic [WORD_W-1:0] wordSel;
  view_e             viewSel;

  pin_irq_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe),
    .wordSel (wordSel),
    .viewSel (viewSel)
  );

  pin_irq_datapath #(
    .NUM_PINS    (NUM_PINS),
    .DATA_W      (DATA_W),
    .NUM_WORDS   (NUM_WORDS),
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .strobe  (strobe),
    .wordSel (wordSel),
    .viewSel (viewSel),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/pin_event_irq_tb.sv
module pin_event_irq_tb_top;

  localparam int NP = 31;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic [3:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          irqOut;

  int nChecks = 0;
  int nFails  = 0;

  // Reference state
  logic [NP-1:0] mS1 = '0, mS2 = '0, mPrev = '0, mRise = '0, mFall = '0;
  logic [3:0]    mEn [NP];
  logic          mIrq = 1'b0;

  always #4 clk = ~clk;

  pin_event_irq dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  // R1 layout: {rise, fall, high, low}
  function automatic logic [3:0] rawField(int p);
    return {mRise[p], mFall[p], mS2[p], ~mS2[p]};
  endfunction

  function automatic logic [31:0] expWord(logic [3:0] addr);
    logic [31:0] w = '0;
    for (int i = 0; i < 8; i++) begin
      int p = int'(addr[1:0]) * 8 + i;
      if (p < NP) begin
        case (addr[3:2])
          2'd0: w[i*4 +: 4] = mEn[p];
          2'd1: w[i*4 +: 4] = rawField(p) & mEn[p];
          2'd2: w[i*4 +: 4] = rawField(p);
          default: w[i*4 +: 4] = 4'h0;
        endcase
      end
    end
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive, advance, update the reference model
  task automatic cycle(logic [NP-1:0] pins, logic we, logic [3:0] addr, logic [31:0] data);
    logic irqNext = 1'b0;
    pinIn = pins; regAddr = addr; regWrEn = we; regWrData = data;
    @(posedge clk);
    for (int p = 0; p < NP; p++) irqNext |= |(rawField(p) & mEn[p]);
    for (int p = 0; p < NP; p++) begin
      logic hit = we && (int'(addr[1:0]) == p / 8);
      logic nr = mS2[p] & ~mPrev[p];
      logic nf = ~mS2[p] & mPrev[p];
      logic cr = hit && addr[3:2] == 2'd2 && data[(p%8)*4+3];
      logic cf = hit && addr[3:2] == 2'd2 && data[(p%8)*4+2];
      mRise[p] = (mRise[p] & ~cr) | nr;
      mFall[p] = (mFall[p] & ~cf) | nf;
      if (hit && addr[3:2] == 2'd0) mEn[p] = data[(p%8)*4 +: 4];
    end
    mPrev = mS2; mS2 = mS1; mS1 = pins;
    mIrq = irqNext;
    #1;
    regWrEn = 1'b0;
  endtask

  task automatic readChk(logic [3:0] addr, string tag);
    regAddr = addr;
    #1;
    chk(tag, regRdData, expWord(addr));
  endtask

  initial begin
    #(8 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [NP-1:0] pins = '0;
    void'($urandom(32'h5EED_0042));
    for (int p = 0; p < NP; p++) mEn[p] = 4'h0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    #1;

    // R9 / R2: reset state, low-level bits set, everything else clear
    for (int a = 0; a < 16; a++) readChk(4'(a), "R9 R10 reset view");
    chk("R9 irq after reset", {31'd0, irqOut}, 32'd0);

    // R2: latency of the level bits, pin 9 high bit is word 1 bit 5
    pins[9] = 1'b1;
    cycle(pins, 1'b0, 4'h0, 32'h0);
    regAddr = 4'h9; #1;
    chk("R2 level not yet visible", {31'd0, regRdData[5]}, 32'd0);
    cycle(pins, 1'b0, 4'h0, 32'h0);
    regAddr = 4'h9; #1;
    chk("R2 level visible", {31'd0, regRdData[5]}, 32'd1);
    chk("R1 low bit cleared", {31'd0, regRdData[4]}, 32'd0);
    cycle(pins, 1'b0, 4'h0, 32'h0);
    regAddr = 4'h9; #1;
    chk("R3 rise latched", {31'd0, regRdData[7]}, 32'd1);

    // R8: enable high level of pin 9, interrupt one cycle after masked
    cycle(pins, 1'b1, 4'h1, 32'h0000_0020);
    chk("R8 irq not before delay", {31'd0, irqOut}, 32'd0);
    readChk(4'h5, "R7 masked word1");
    cycle(pins, 1'b0, 4'h0, 32'h0);
    chk("R8 irq raised", {31'd0, irqOut}, {31'd0, mIrq});
    chk("R8 irq raised direct", {31'd0, irqOut}, 32'd1);

    // R7 / R10: writes to masked and spare views change nothing
    cycle(pins, 1'b1, 4'h5, 32'hFFFF_FFFF);
    cycle(pins, 1'b1, 4'hD, 32'hFFFF_FFFF);
    readChk(4'h1, "R7 enable untouched");
    readChk(4'h9, "R10 raw untouched");

    // R6: pin 31 field unused
    cycle(pins, 1'b1, 4'h3, 32'hFFFF_FFFF);
    regAddr = 4'h3; #1;
    chk("R6 unused field zero", regRdData, 32'h0FFF_FFFF);
    cycle(pins, 1'b1, 4'h3, 32'h0);
    cycle(pins, 1'b1, 4'h1, 32'h0);

    // R4 / R5: clear all edges then clear collides with a new edge on pin 5
    cycle(pins, 1'b1, 4'h8, 32'hFFFF_FFFF);
    cycle(pins, 1'b1, 4'h9, 32'hFFFF_FFFF);
    pins[5] = 1'b1;
    cycle(pins, 1'b0, 4'h0, 32'h0);
    cycle(pins, 1'b0, 4'h0, 32'h0);
    cycle(pins, 1'b1, 4'h8, 32'hFFFF_FFFF);
    regAddr = 4'h8; #1;
    chk("R5 edge wins over clear", {31'd0, regRdData[23]}, 32'd1);
    chk("R4 level kept on clear", {31'd0, regRdData[21]}, 32'd1);
    cycle(pins, 1'b1, 4'h8, 32'h0000_0000);
    regAddr = 4'h8; #1;
    chk("R4 zero write keeps edge", {31'd0, regRdData[23]}, 32'd1);
    cycle(pins, 1'b1, 4'h8, 32'h0080_0000);
    regAddr = 4'h8; #1;
    chk("R4 one write clears edge", {31'd0, regRdData[23]}, 32'd0);
    readChk(4'h8, "R4 raw word0");

    // Random phase: R1 R2 R3 R4 R6 R7 R8 R10 against the reference model
    for (int n = 0; n < 4000; n++) begin
      logic we = ($urandom % 10) < 3;
      logic [3:0] a = 4'($urandom);
      logic [31:0] d = $urandom;
      pins = pins ^ NP'($urandom & $urandom & $urandom);
      cycle(pins, we, a, d);
      readChk(4'($urandom), "R1/R2/R3/R4/R6/R7/R10 random read");
      chk("R8 random irq", {31'd0, irqOut}, {31'd0, mIrq});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule